// File: doc/BRIEF.md
# Bit-Plane Frame Memory Address Generator

This block generates the write and read addresses for a display frame memory organised as bit planes. Each pixel carries PLANES bits of intensity. The memory is split into PLANES equal slices, one per bit weight. Every memory word holds one bit of the same weight for eight neighbouring columns. A slice therefore holds COL_WORDS × ROWS words, which covers a dot matrix of 8·COL_WORDS columns by ROWS rows.

The two sides walk the memory in different orders. The write side serves a pixel reorganiser that emits, for each group of eight pixels, one word per bit weight, starting with the least significant. Its address therefore steps through planes fastest, then column words, then rows. The read side serves the display refresh. It scans every column word of a row, then every row, and only then moves on to the next bit plane, so the driver chain receives one complete plane at a time.

A frame-start pulse clears both sequences together. This keeps the write and read positions locked to the same frame boundary. Each address moves on by one position for every write strobe or read request it receives.

Top module: `bp_frame_addr_gen`

## Requirements
- R1: After reset, wrAddr and rdAddr are 0 and wrFrameDone, rdRowEnd and rdPlaneEnd are low (with COL_WORDS > 1).
- R2: Every address equals plane × (COL_WORDS × ROWS) + row × COL_WORDS + colWord, where plane, row and colWord are the current positions of that side.
- R3: Write sequencing: each wrStrobe advances the plane first (from bit 0 up to PLANES-1), then the column word, then the row.
- R4: Read sequencing: each rdReq advances the column word first, then the row, then the plane, so rdAddr counts up by one per request.
- R5: After the last word of the last plane, the next rdReq returns rdAddr to 0 (plane 0, row 0, column word 0).
- R6: After the last write position, the next wrStrobe returns wrAddr to 0, and wrFrameDone is high for exactly the one cycle that follows that strobe.
- R7: A frameStart pulse sets both addresses to 0 on the next cycle. It overrides any wrStrobe or rdReq in the same cycle, and it does not raise wrFrameDone.
- R8: Without wrStrobe, wrAddr holds its value. Without rdReq, rdAddr holds its value.
- R9: rdRowEnd is high while the read column word is COL_WORDS-1. rdPlaneEnd is high while both the read column word and the read row are at their last values.
- R10: The two sides are independent. A wrStrobe and an rdReq in the same cycle each advance their own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Frame boundary pulse; clears both sides |
| wrStrobe | input | 1 | One reorganised word is written at wrAddr this cycle |
| rdReq | input | 1 | One word is read at rdAddr this cycle |
| wrAddr | output | AddrW | Current write address |
| wrFrameDone | output | 1 | One-cycle pulse after the last word of the frame is written |
| rdAddr | output | AddrW | Current read address |
| rdRowEnd | output | 1 | Read position is on the last column word of a row |
| rdPlaneEnd | output | 1 | Read position is on the last word of a plane |

## Verification
A full frame of back-to-back write strobes is compared with the plane-first order. This separates a correct nesting from a swapped one, because a swapped order would produce sequential addresses where strides of a whole slice are expected. A run of more than one frame of read requests exposes a wrong read nesting and a missing or early wrap. The edge flags are checked on every one of those cycles.

The bench also drives idle stretches, cycles where both sides step together, and frame-start pulses that collide with strobes. These show that the two sides are independent and that the clear takes priority. A long random mix of all three inputs is then checked against models, in the bench, of both positions. This catches off-by-one carries at every digit boundary.

// File: rtl/bp_addr_pkg.sv
package bp_addr_pkg;

  // Strobes sent from the control to the address datapath, one cycle each.
  typedef struct packed {
    logic clear;   // return both sides to position zero
    logic wrStep;  // advance the write position
    logic rdStep;  // advance the read position
  } bp_strobes_t;

  function automatic int unsigned idxWidth(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

  function automatic bit isPow2(input int unsigned v);
    return (v > 1) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/bp_nest_counter.sv
// Three-digit nested counter: idx0 runs fastest, idx2 slowest.
module bp_nest_counter
  import bp_addr_pkg::*;
#(
  parameter int unsigned L0 = 8,
  parameter int unsigned L1 = 4,
  parameter int unsigned L2 = 8,
  localparam int unsigned W0 = idxWidth(L0),
  localparam int unsigned W1 = idxWidth(L1),
  localparam int unsigned W2 = idxWidth(L2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          step,
  output logic [W0-1:0] idx0,
  output logic [W1-1:0] idx1,
  output logic [W2-1:0] idx2
);

  localparam logic [W0-1:0] Last0 = W0'(L0 - 1);
  localparam logic [W1-1:0] Last1 = W1'(L1 - 1);
  localparam logic [W2-1:0] Last2 = W2'(L2 - 1);

  logic wrap0, wrap1, wrap2;

  assign wrap0 = (idx0 == Last0);
  assign wrap1 = (idx1 == Last1);
  assign wrap2 = (idx2 == Last2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx0 <= '0;
      idx1 <= '0;
      idx2 <= '0;
    end else if (clear) begin
      idx0 <= '0;
      idx1 <= '0;
      idx2 <= '0;
    end else if (step) begin
      idx0 <= wrap0 ? '0 : idx0 + 1'b1;
      if (wrap0) begin
        idx1 <= wrap1 ? '0 : idx1 + 1'b1;
        if (wrap1) begin
          idx2 <= wrap2 ? '0 : idx2 + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bp_addr_ctrl.sv
// Turns the boundary inputs into datapath strobes and flags the end of a written frame.
module bp_addr_ctrl
  import bp_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        wrStrobe,
  input  logic        rdReq,
  input  logic        wrAtLast,
  output bp_strobes_t strobes,
  output logic        wrFrameDone
);

  always_comb begin
    strobes.clear  = frameStart;
    strobes.wrStep = wrStrobe & ~frameStart;
    strobes.rdStep = rdReq & ~frameStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrFrameDone <= 1'b0;
    end else begin
      wrFrameDone <= strobes.wrStep & wrAtLast;
    end
  end

endmodule

// File: rtl/bp_addr_path.sv
// Holds both position counters and forms the two memory addresses.
module bp_addr_path
  import bp_addr_pkg::*;
#(
  parameter int unsigned PLANES    = 8,
  parameter int unsigned COL_WORDS = 4,
  parameter int unsigned ROWS      = 8,
  parameter int unsigned AW        = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  bp_strobes_t   strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrAtLast,
  output logic          rdRowEnd,
  output logic          rdPlaneEnd
);

  localparam int unsigned WP = idxWidth(PLANES);
  localparam int unsigned WC = idxWidth(COL_WORDS);
  localparam int unsigned WR = idxWidth(ROWS);
  localparam int unsigned PlaneWords = COL_WORDS * ROWS;
  localparam bit Packed = isPow2(COL_WORDS) && isPow2(ROWS);

  logic [WP-1:0] wrPlane, rdPlane;
  logic [WC-1:0] wrCol, rdCol;
  logic [WR-1:0] wrRow, rdRow;

  // Write side: plane fastest, then column word, then row.
  bp_nest_counter #(.L0(PLANES), .L1(COL_WORDS), .L2(ROWS)) i_wrCount (
    .clk  (clk),
    .rstN (rstN),
    .clear(strobes.clear),
    .step (strobes.wrStep),
    .idx0 (wrPlane),
    .idx1 (wrCol),
    .idx2 (wrRow)
  );

  // Read side: column word fastest, then row, then plane.
  bp_nest_counter #(.L0(COL_WORDS), .L1(ROWS), .L2(PLANES)) i_rdCount (
    .clk  (clk),
    .rstN (rstN),
    .clear(strobes.clear),
    .step (strobes.rdStep),
    .idx0 (rdCol),
    .idx1 (rdRow),
    .idx2 (rdPlane)
  );

  generate
    if (Packed) begin : g_concat
      // Power-of-two dimensions: the address is a plain field concatenation.
      assign wrAddr = AW'({wrPlane, wrRow, wrCol});
      assign rdAddr = AW'({rdPlane, rdRow, rdCol});
    end else begin : g_mult
      localparam logic [AW-1:0] SliceK = AW'(PlaneWords);
      localparam logic [AW-1:0] RowK   = AW'(COL_WORDS);
      assign wrAddr = AW'(wrPlane) * SliceK + AW'(wrRow) * RowK + AW'(wrCol);
      assign rdAddr = AW'(rdPlane) * SliceK + AW'(rdRow) * RowK + AW'(rdCol);
    end
  endgenerate

  assign wrAtLast   = (wrPlane == WP'(PLANES - 1)) && (wrCol == WC'(COL_WORDS - 1))
                    && (wrRow == WR'(ROWS - 1));
  assign rdRowEnd   = (rdCol == WC'(COL_WORDS - 1));
  assign rdPlaneEnd = rdRowEnd && (rdRow == WR'(ROWS - 1));

endmodule

// File: rtl/bp_frame_addr_gen.sv
module bp_frame_addr_gen
  import bp_addr_pkg::*;
#(
  parameter int unsigned PLANES    = 8,
  parameter int unsigned COL_WORDS = 4,
  parameter int unsigned ROWS      = 8,
  localparam int unsigned AddrW = idxWidth(PLANES * COL_WORDS * ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             wrStrobe,
  input  logic             rdReq,
  output logic [AddrW-1:0] wrAddr,
  output logic             wrFrameDone,
  output logic [AddrW-1:0] rdAddr,
  output logic             rdRowEnd,
  output logic             rdPlaneEnd
);

  bp_strobes_t strobes;
  logic        wrAtLast;

  bp_addr_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .wrStrobe   (wrStrobe),
    .rdReq      (rdReq),
    .wrAtLast   (wrAtLast),
    .strobes    (strobes),
    .wrFrameDone(wrFrameDone)
  );

  bp_addr_path #(
    .PLANES(PLANES), .COL_WORDS(COL_WORDS), .ROWS(ROWS), .AW(AddrW)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .wrAtLast  (wrAtLast),
    .rdRowEnd  (rdRowEnd),
    .rdPlaneEnd(rdPlaneEnd)
  );

endmodule

// File: rtl/bp_frame_addr_chk.sv
module bp_frame_addr_chk #(
  parameter int unsigned PLANES    = 8,
  parameter int unsigned COL_WORDS = 4,
  parameter int unsigned ROWS      = 8,
  parameter int unsigned AW        = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          frameStart,
  input logic          wrStrobe,
  input logic          rdReq,
  input logic [AW-1:0] wrAddr,
  input logic          wrFrameDone,
  input logic [AW-1:0] rdAddr,
  input logic          rdRowEnd,
  input logic          rdPlaneEnd
);

  localparam int Slice = COL_WORDS * ROWS;
  localparam int Total = PLANES * Slice;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (wrAddr == '0) && (rdAddr == '0) && !wrFrameDone);

  assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !frameStart && (int'(rdAddr) != Total - 1) |=> int'(rdAddr) == int'($past(rdAddr)) + 1);

  assert_rd_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !frameStart && (int'(rdAddr) == Total - 1) |=> rdAddr == '0);

  assert_wr_plane_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && !frameStart && (int'(wrAddr) < (PLANES - 1) * Slice)
    |=> int'(wrAddr) == int'($past(wrAddr)) + Slice);

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe && !frameStart |=> $stable(wrAddr));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq && !frameStart |=> $stable(rdAddr));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrFrameDone) |-> (wrAddr == '0) && $past(wrStrobe));

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdPlaneEnd |-> rdRowEnd && ((int'(rdAddr) % Slice) == Slice - 1));

endmodule

bind bp_frame_addr_gen bp_frame_addr_chk #(
  .PLANES(PLANES), .COL_WORDS(COL_WORDS), .ROWS(ROWS), .AW(AddrW)
) i_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .wrStrobe(wrStrobe),
  .rdReq(rdReq), .wrAddr(wrAddr), .wrFrameDone(wrFrameDone), .rdAddr(rdAddr),
  .rdRowEnd(rdRowEnd), .rdPlaneEnd(rdPlaneEnd)
);

// File: tb/test_bp_frame_addr_gen.sv
`timescale 1ns/1ps
module test_bp_frame_addr_gen;

  localparam int P = 8;
  localparam int C = 4;
  localparam int R = 8;
  localparam int TOTAL = P * C * R;
  localparam int AW = $clog2(TOTAL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, wrStrobe = 1'b0, rdReq = 1'b0;
  logic [AW-1:0] wrAddr, rdAddr;
  logic wrFrameDone, rdRowEnd, rdPlaneEnd;

  int errors = 0;
  int checks = 0;
  int wIdx = 0;
  int rIdx = 0;
  bit expDone = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bp_frame_addr_gen #(.PLANES(P), .COL_WORDS(C), .ROWS(R)) i_bp_frame_addr_gen (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .wrStrobe(wrStrobe), .rdReq(rdReq),
    .wrAddr(wrAddr), .wrFrameDone(wrFrameDone), .rdAddr(rdAddr),
    .rdRowEnd(rdRowEnd), .rdPlaneEnd(rdPlaneEnd)
  );

  // Write order model: plane fastest, then column word, then row (R2, R3).
  function automatic int wrExp(input int k);
    int pl, co, ro;
    pl = k % P;
    co = (k / P) % C;
    ro = (k / (P * C)) % R;
    return pl * C * R + ro * C + co;
  endfunction

  // Read order model: column word, row, plane (R2, R4).
  function automatic int rdExp(input int k);
    int co, ro, pl;
    co = k % C;
    ro = (k / C) % R;
    pl = k / (C * R);
    return pl * C * R + ro * C + co;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "wrAddr", int'(wrAddr), wrExp(wIdx));
    chk(tag, "rdAddr", int'(rdAddr), rdExp(rIdx));
    chk("R6", "wrFrameDone", int'(wrFrameDone), int'(expDone));
    chk("R9", "rdRowEnd", int'(rdRowEnd), int'((rIdx % C) == C - 1));
    chk("R9", "rdPlaneEnd", int'(rdPlaneEnd), int'((rIdx % (C * R)) == C * R - 1));
  endtask

  // Drive one cycle of inputs, update the models at the edge, check at the falling edge.
  task automatic step(input bit fs, input bit ws, input bit rq, input string tag);
    frameStart = fs;
    wrStrobe   = ws;
    rdReq      = rq;
    @(posedge clk);
    expDone = !fs && ws && (wIdx == TOTAL - 1);
    if (fs) begin
      wIdx = 0;
      rIdx = 0;
    end else begin
      if (ws) wIdx = (wIdx + 1) % TOTAL;
      if (rq) rIdx = (rIdx + 1) % TOTAL;
    end
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");                                  // R1 reset state

    repeat (4) step(0, 0, 0, "R8");                  // R8 idle holds both
    for (int i = 0; i < TOTAL; i++) step(0, 1, 0, "R3");  // R3 full frame of writes
    step(0, 0, 0, "R6");                             // R6 done pulse ends
    for (int i = 0; i < 10; i++) step(0, 1, 0, "R6");      // R6 second frame after wrap
    for (int i = 0; i < TOTAL + 20; i++) step(0, 0, 1, "R4"); // R4 read scan, R5 wrap
    chk("R5", "rdAddr after wrap", int'(rdAddr), 20);
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R8"); // R8 rdAddr untouched by writes
    for (int i = 0; i < 40; i++) step(0, 1, 1, "R10"); // R10 both sides together
    step(1, 1, 1, "R7");                             // R7 clear wins over strobes
    chk("R7", "wrAddr cleared", int'(wrAddr), 0);
    chk("R7", "rdAddr cleared", int'(rdAddr), 0);
    for (int i = 0; i < TOTAL - 1; i++) step(0, 1, 0, "R6");
    step(1, 1, 0, "R7");                             // R7 no done pulse on cleared last write

    for (int i = 0; i < 3000; i++) begin             // R2 random mix
      bit fs, ws, rq;
      fs = ($urandom % 97) == 0;
      ws = ($urandom % 4) != 0;
      rq = ($urandom % 3) != 0;
      step(fs, ws, rq, "R2");
    end
    step(0, 0, 0, "R8");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule